// File: doc/BRIEF.md
# PHY Management Register Slave (Software-Clocked)

This block stands in for the management side of an Ethernet PHY that host software drives by toggling bits in a control register. Software writes a management-clock bit, a data-out bit and a direction bit. Each write that takes the clock bit from 0 to 1 shifts one data bit into a 32-bit shift word and advances a bit counter. At fixed counts the block decodes a read frame or a write frame against its file of 32 registers, each 16 bits wide.

Read data comes back on a data-in bit, which software sees in the same control register. Only this block drives that bit. A run of ones that fills the shift word acts as the preamble and restarts the counter. Each register has a reset default and a write mask. Only one PHY address answers.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After reset `ctl_rdata` is 0 and the bit counter is 0. Control bit positions are: bit 0 management clock, bit 1 data-out, bit 2 direction (1 = read), bit 3 data-in (read-only).
- R2: Shifting and decoding happen only on a control write that changes bit 0 from 0 to 1. A write that keeps bit 0 at 1 or clears it changes nothing in the frame state.
- R3: On each rising edge the counter increments and the word shifts left by one bit. The new bit is data-out when the incremented count is below 16 or the direction bit is 0. Otherwise the new bit is 0.
- R4: When the shift word becomes all ones, the counter returns to 0, so garbage bits ahead of a preamble are discarded.
- R5: At count 16, word bits [15:12] are the opcode, [11:7] the PHY address and [6:2] the register. Opcode 6 loads the register value into word bits [15:0].
- R6: From count 16 on, with direction 1, data-in takes word bit 15 after each edge. As a result, register bits 14 down to 0 appear after edges 17 through 31, and data-in is 0 at edges 32 to 40.
- R7: At count 32, word bits [31:28] are the opcode, [27:23] the PHY address, [22:18] the register and [15:0] the data. Opcode 5 writes the register.
- R8: Only PHY address 1 responds. Reads of any other address return 0, and writes to them leave every register unchanged.
- R9: A write changes only the bits set in the register's mask. Register 0 has mask 0x0000, register 4 has 0xC01F, register 16 has 0x0FFF, and registers 1-3, 5-6 and 18-25 have 0xFFFF. All other masks are 0.
- R10: Reset defaults are 0x3100, 0xF02C, 0x7810, 0x0000, 0x0501 and 0x4181 for registers 0 to 5, 0x0003 for register 16, and 0 for all others.
- R11: A software write of bit 3 never changes the data-in bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Software write strobe for the control register |
| ctl_wdata | input | 4 | Written control value (clock, data-out, direction, ignored data-in) |
| ctl_rdata | output | 4 | Control register readback with data-in in bit 3 |

## Verification
Read frames are run against every register with a stated default. Together they separate correct opcode, address and register decoding from a frame that hits the wrong register. Write frames use all-ones data on masked registers and ordinary data on open ones, which separates masking from plain storage. A write aimed at another PHY address separates address gating from an unconditional write. Further runs place duplicate clock-high writes, garbage bits before the preamble, and data-out held high during read data, which catch edge detection, counter restart and the read-direction shift rule in turn.

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs #(
  parameter int NREG     = 32,
  parameter int DW       = 16,
  parameter int PHY_ADDR = 1,
  parameter int CW       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  output logic [3:0] ctl_rdata
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] CNT_CMD = CW'(16);
  localparam logic [CW-1:0] CNT_WR  = CW'(32);

  function automatic logic [DW-1:0] dflt(input int i);
    case (i)
      0:  dflt = DW'(16'h3100);
      1:  dflt = DW'(16'hF02C);
      2:  dflt = DW'(16'h7810);
      4:  dflt = DW'(16'h0501);
      5:  dflt = DW'(16'h4181);
      16: dflt = DW'(16'h0003);
      default: dflt = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] wmask(input int i);
    if (i == 4)                                       wmask = DW'(16'hC01F);
    else if (i == 16)                                 wmask = DW'(16'h0FFF);
    else if ((i >= 1 && i <= 6) || (i >= 18 && i <= 25)) wmask = '1;
    else                                              wmask = '0;
  endfunction

  logic [2:0]    ctl_q;
  logic          mdi;
  logic [CW-1:0] cnt;
  logic [31:0]   word;
  logic [DW-1:0] regs [NREG];

  logic          rise, shin, pre, do_rd, do_wr;
  logic [CW-1:0] cnt_inc;
  logic [31:0]   word_sh;
  logic [DW-1:0] rd_val;
  logic [4:0]    wr_reg;

  assign rise    = ctl_we & ctl_wdata[0] & ~ctl_q[0];
  assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CW'(1);
  assign shin    = ctl_wdata[1] & ((cnt_inc < CNT_CMD) | ~ctl_wdata[2]);
  assign word_sh = {word[30:0], shin};
  assign pre     = &word_sh;
  assign rd_val  = (word_sh[11:7] == 5'(PHY_ADDR)) ? regs[word_sh[6:2]] : '0;
  assign do_rd   = rise & ~pre & (cnt_inc == CNT_CMD) & (word_sh[15:12] == 4'd6);
  assign wr_reg  = word_sh[22:18];
  assign do_wr   = rise & ~pre & (cnt_inc == CNT_WR) & (word_sh[31:28] == 4'd5)
                 & (word_sh[27:23] == 5'(PHY_ADDR));
  assign ctl_rdata = {mdi, ctl_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      mdi   <= 1'b0;
      cnt   <= '0;
      word  <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata[2:0];
      if (rise) begin
        if (cnt_inc >= CNT_CMD && ctl_wdata[2]) mdi <= word_sh[15];
        cnt  <= pre ? '0 : cnt_inc;
        word <= do_rd ? {{(32-DW){1'b0}}, rd_val} : word_sh;
      end
      if (do_wr)
        regs[wr_reg] <= (regs[wr_reg] & ~wmask(int'(wr_reg)))
                      | (word_sh[DW-1:0] & wmask(int'(wr_reg)));
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(cnt) && $stable(word) && $stable(mdi));

  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !pre && cnt != CNT_MAX) |=> cnt == $past(cnt) + CW'(1));

  assert_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&word) |-> cnt == '0);

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[0]) && ((regs[4] & ~DW'(16'hC01F)) == (DW'(16'h0501) & ~DW'(16'hC01F))));

  assert_write_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !do_wr |=> $stable(regs[3]) && $stable(regs[1]));

  assert_sw_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !rise) |=> $stable(mdi));

endmodule

// File: tb/sim_mii_mgmt_regs.sv
module sim_mii_mgmt_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic [3:0] ctl_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mii_mgmt_regs u0 (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
                    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic bit_edge(input logic dout, input logic dir, input bit dbl);
    ctl_write({1'b0, dir, dout, 1'b0});
    ctl_write({1'b0, dir, dout, 1'b1});
    if (dbl) ctl_write({1'b1, dir, ~dout, 1'b1});
  endtask

  task automatic preamble();
    for (int i = 0; i < 32; i++) bit_edge(1'b1, 1'b0, 1'b0);
  endtask

  task automatic mii_read(input logic [4:0] phy, input logic [4:0] rg, input bit dbl,
                          output logic [14:0] got, output bit tail_ok);
    logic [15:0] cmd;
    cmd = {4'b0110, phy, rg, 2'b00};
    tail_ok = 1'b1;
    preamble();
    for (int i = 15; i >= 0; i--) bit_edge(cmd[i], 1'b0, dbl);
    for (int k = 17; k <= 40; k++) begin
      bit_edge(1'b1, 1'b1, dbl);
      if (k <= 31) got[31-k] = ctl_rdata[3];
      else if (ctl_rdata[3] !== 1'b0) tail_ok = 1'b0;
    end
  endtask

  task automatic mii_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] f;
    f = {4'b0101, phy, rg, 2'b10, d};
    preamble();
    for (int i = 31; i >= 0; i--) bit_edge(f[i], 1'b0, 1'b0);
  endtask

  task automatic expect_reg(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp,
                            input bit dbl, input string tag);
    logic [14:0] got;
    bit tail;
    mii_read(phy, rg, dbl, got, tail);
    check(got === exp[14:0], tag, {17'b0, got}, {17'b0, exp[14:0]});
    check(tail, {tag, " R3 R6 data-in after edge 31"}, {31'b0, ~tail}, 32'h0);
  endtask

  task automatic t_reset();
    check(ctl_rdata === 4'h0, "R1 reset readback", {28'b0, ctl_rdata}, 32'h0);
    expect_reg(5'd1, 5'd0, 16'h3100, 1'b0, "R10 R5 reg0 default");
    expect_reg(5'd1, 5'd1, 16'hF02C, 1'b0, "R10 reg1 default");
    expect_reg(5'd1, 5'd2, 16'h7810, 1'b0, "R10 reg2 default");
    expect_reg(5'd1, 5'd3, 16'h0000, 1'b0, "R10 reg3 default");
    expect_reg(5'd1, 5'd4, 16'h0501, 1'b0, "R10 reg4 default");
    expect_reg(5'd1, 5'd5, 16'h4181, 1'b0, "R10 reg5 default");
    expect_reg(5'd1, 5'd16, 16'h0003, 1'b0, "R10 reg16 default");
  endtask

  task automatic t_writes();
    mii_write(5'd1, 5'd3, 16'h2A55);
    expect_reg(5'd1, 5'd3, 16'h2A55, 1'b0, "R7 reg3 plain write");
    mii_write(5'd1, 5'd4, 16'hFFFF);
    expect_reg(5'd1, 5'd4, 16'hC51F, 1'b0, "R9 reg4 mask");
    mii_write(5'd1, 5'd16, 16'hABCD);
    expect_reg(5'd1, 5'd16, 16'h0BCD, 1'b0, "R9 reg16 mask");
    mii_write(5'd1, 5'd0, 16'h1234);
    expect_reg(5'd1, 5'd0, 16'h3100, 1'b0, "R9 reg0 read-only");
  endtask

  task automatic t_phy();
    mii_write(5'd2, 5'd3, 16'h1111);
    expect_reg(5'd1, 5'd3, 16'h2A55, 1'b0, "R8 foreign write ignored");
    expect_reg(5'd2, 5'd3, 16'h0000, 1'b0, "R8 foreign read zero");
  endtask

  task automatic t_edge();
    expect_reg(5'd1, 5'd3, 16'h2A55, 1'b1, "R2 repeated clock-high writes");
  endtask

  task automatic t_preamble();
    bit_edge(1'b0, 1'b0, 1'b0);
    bit_edge(1'b1, 1'b0, 1'b0);
    bit_edge(1'b0, 1'b0, 1'b0);
    bit_edge(1'b0, 1'b0, 1'b0);
    bit_edge(1'b1, 1'b0, 1'b0);
    expect_reg(5'd1, 5'd2, 16'h7810, 1'b0, "R4 garbage before preamble");
  endtask

  task automatic t_sw_bit();
    logic [15:0] cmd;
    ctl_write(4'b1000);
    check(ctl_rdata[3] === 1'b0, "R11 sw set of data-in", {31'b0, ctl_rdata[3]}, 32'h0);
    cmd = {4'b0110, 5'd1, 5'd3, 2'b00};
    preamble();
    for (int i = 15; i >= 0; i--) bit_edge(cmd[i], 1'b0, 1'b0);
    bit_edge(1'b0, 1'b1, 1'b0);
    bit_edge(1'b0, 1'b1, 1'b0);
    check(ctl_rdata[3] === 1'b1, "R6 data bit13 of reg3", {31'b0, ctl_rdata[3]}, 32'h1);
    ctl_write(4'b0100);
    check(ctl_rdata[3] === 1'b1, "R11 sw clear of data-in", {31'b0, ctl_rdata[3]}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_writes();
    t_phy();
    t_edge();
    t_preamble();
    t_sw_bit();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule